// File: doc/BRIEF.md
# PS/2 Device-Side Link Controller

This block is the device end of a two-wire, open-drain PS/2 link in which the device always produces the clock. A byte handed over on the transmit interface is sent as an eleven-bit frame when the host leaves both wires high. A request from the host is shifted in under the device's own clock and handed back with parity and framing status. Commands and report contents belong to the layer above.

The block never drives a wire high. It only asserts pull-low enables and reads the resolved wire levels back through a two-flop synchroniser. Every clock phase, the data sampling point and the data update point are counted in system clock ticks. These counts are set by two parameters.

The host may cut a transmission short by pulling the clock low. If it does so early, the byte stays in the block and is sent again in full. If it does so late, the byte counts as delivered. A receive ends with an acknowledge clock. While the stop bit reads low, the block keeps clocking until the data wire goes high.

Top module: `ps2_dev_link`

## Requirements
- R1: Directly after reset, neither pull-low enable is asserted, `tx_ready` is 1 and `rx_valid` is 0.
- R2: A transmitted frame carries 11 bits in this order on successive device clock falls: a 0 start bit, the byte LSB first, an odd parity bit (total ones over byte plus parity is odd), and a 1 stop bit. `tx_done` pulses once per completed frame.
- R3: The data pull-low changes only while the device clock is released, never on a clock edge. It is updated SAMPLE_TICKS into a high phase.
- R4: A frame starts only after both wires have been seen high. While the host holds the clock low, a pending byte waits, no clock is produced, `tx_ready` stays 0 and neither wire is pulled.
- R5: When the clock wire is high and the host holds data low, the block clocks in a request. It takes the data bits LSB first on the first eight clocks, parity on the ninth and stop on the tenth, then pulses `rx_valid` with the byte on `rx_byte`.
- R6: If the host holds the clock low at a check point before the tenth rising edge, the block releases both wires. It keeps the byte (`tx_ready` stays 0), gives no `tx_done`, and later sends the whole frame again once the wires are free.
- R7: A clock pulled low by the host after the tenth rising edge does not stop the frame. `tx_done` pulses, the byte is dropped and nothing is resent.
- R8: After a high stop bit, the block pulls data low and gives one more clock as acknowledge. It releases data when that clock ends, in the same cycle that `rx_valid` is raised.
- R9: A received byte whose parity bit does not make the ones count odd is still delivered, with `rx_parity_err` = 1.
- R10: If the stop bit reads low, the block keeps clocking until data reads high, then gives the acknowledge clock. It delivers the byte with `rx_frame_err` = 1.
- R11: Every device clock low phase and high phase lasts exactly HALF_TICKS system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Byte offered for transmission |
| tx_byte | input | 8 | Byte to transmit |
| tx_ready | output | 1 | No byte pending; an offer is taken this cycle |
| tx_done | output | 1 | One-cycle pulse when a frame has been fully sent |
| rx_valid | output | 1 | One-cycle pulse when a received byte is available |
| rx_byte | output | 8 | Last received byte |
| rx_parity_err | output | 1 | Parity check failed on the last received byte |
| rx_frame_err | output | 1 | Stop bit was low on the last received byte |
| clk_line_in | input | 1 | Resolved level of the clock wire |
| data_line_in | input | 1 | Resolved level of the data wire |
| clk_drive_low | output | 1 | Pull-low enable for the clock wire |
| data_drive_low | output | 1 | Pull-low enable for the data wire |

## Verification
The bench builds the block with HALF_TICKS = 10 and SAMPLE_TICKS = 4. A full frame then takes about 220 system cycles. Inhibit, early and late contention, and a stretched framing error all fit in one short run. At these values the sampling point lies two ticks past the synchroniser delay. This means a host pull on the clock during a low phase reaches the very next check point, and a host data change made right after a fall has settled long before it is sampled.

// File: rtl/ps2_link_pkg.sv
package ps2_link_pkg;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = DATA_W + 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TX_HI, ST_TX_LO, ST_RX_LO, ST_RX_HI, ST_ACK_LO, ST_ACK_HI, ST_RECOVER
  } link_state_e;

  // parity bit that makes the ones count of byte plus bit odd
  function automatic logic odd_bit(input logic [DATA_W-1:0] b);
    return ~(^b);
  endfunction

  // frame as sent: index 0 goes first
  function automatic logic [FRAME_W-1:0] build_frame(input logic [DATA_W-1:0] b);
    return {1'b1, odd_bit(b), b, 1'b0};
  endfunction

  function automatic logic parity_bad(input logic [DATA_W-1:0] b, input logic p);
    return ~(^{b, p});
  endfunction
endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ps2_phase_timer.sv
module ps2_phase_timer #(
  parameter int HALF_TICKS   = 429,
  parameter int SAMPLE_TICKS = 143
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic at_sample,
  output logic at_end
);
  localparam int CW = $clog2(HALF_TICKS + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  assign at_sample = (cnt == CW'(SAMPLE_TICKS - 1));
  assign at_end    = (cnt == CW'(HALF_TICKS - 1));
endmodule

// File: rtl/ps2_dev_link.sv
module ps2_dev_link
  import ps2_link_pkg::*;
#(
  parameter int HALF_TICKS   = 429,
  parameter int SAMPLE_TICKS = 143
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              tx_ready,
  output logic              tx_done,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_parity_err,
  output logic              rx_frame_err,
  input  logic              clk_line_in,
  input  logic              data_line_in,
  output logic              clk_drive_low,
  output logic              data_drive_low
);
  localparam logic [3:0] LAST_SLOT = 4'(FRAME_W - 1);
  localparam logic [3:0] PAR_SLOT  = 4'(DATA_W);
  localparam logic [3:0] STOP_SLOT = 4'(DATA_W + 1);

  link_state_e        state;
  logic [3:0]         bit_idx;
  logic               pend;
  logic [DATA_W-1:0]  tx_buf;
  logic [FRAME_W-1:0] tx_sh;
  logic               data_low_q;
  logic [DATA_W-1:0]  sreg;
  logic               par_q, ferr_q, ack_q;

  logic clk_s, data_s, at_sample, at_end;

  // named internal events
  logic rts_seen, tx_start, tx_abort, phase_restart;

  ps2_line_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({clk_line_in, data_line_in}),
    .q({clk_s, data_s})
  );

  ps2_phase_timer #(.HALF_TICKS(HALF_TICKS), .SAMPLE_TICKS(SAMPLE_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(phase_restart),
    .at_sample(at_sample), .at_end(at_end)
  );

  assign rts_seen      = (state == ST_IDLE) && clk_s && !data_s;
  assign tx_start      = (state == ST_IDLE) && pend && clk_s && data_s;
  assign tx_abort      = (state == ST_TX_HI) && at_sample && !clk_s && (bit_idx < LAST_SLOT);
  assign phase_restart = (state == ST_IDLE) || at_end || tx_abort;

  assign clk_drive_low  = (state == ST_TX_LO) || (state == ST_RX_LO) || (state == ST_ACK_LO);
  assign data_drive_low = data_low_q;
  assign tx_ready       = !pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_RECOVER;
      bit_idx       <= '0;
      pend          <= 1'b0;
      tx_buf        <= '0;
      tx_sh         <= '0;
      data_low_q    <= 1'b0;
      sreg          <= '0;
      par_q         <= 1'b0;
      ferr_q        <= 1'b0;
      ack_q         <= 1'b0;
      tx_done       <= 1'b0;
      rx_valid      <= 1'b0;
      rx_byte       <= '0;
      rx_parity_err <= 1'b0;
      rx_frame_err  <= 1'b0;
    end else begin
      tx_done  <= 1'b0;
      rx_valid <= 1'b0;
      if (tx_valid && !pend) begin
        pend   <= 1'b1;
        tx_buf <= tx_byte;
      end
      case (state)
        ST_IDLE: begin
          if (rts_seen) begin
            state   <= ST_RX_LO;
            bit_idx <= '0;
            ferr_q  <= 1'b0;
            ack_q   <= 1'b0;
          end else if (tx_start) begin
            state   <= ST_TX_HI;
            bit_idx <= '0;
            tx_sh   <= build_frame(tx_buf);
          end
        end
        ST_TX_HI: begin
          if (tx_abort) begin
            data_low_q <= 1'b0;
            state      <= ST_RECOVER;
          end else begin
            if (at_sample) data_low_q <= ~tx_sh[0];
            if (at_end)    state      <= ST_TX_LO;
          end
        end
        ST_TX_LO: begin
          if (at_end) begin
            if (bit_idx == LAST_SLOT) begin
              state   <= ST_RECOVER;
              pend    <= 1'b0;
              tx_done <= 1'b1;
            end else begin
              bit_idx <= bit_idx + 1'b1;
              tx_sh   <= tx_sh >> 1;
              state   <= ST_TX_HI;
            end
          end
        end
        ST_RX_LO: if (at_end) state <= ST_RX_HI;
        ST_RX_HI: begin
          if (at_sample) begin
            if (bit_idx < PAR_SLOT)       sreg  <= {data_s, sreg[DATA_W-1:1]};
            else if (bit_idx == PAR_SLOT) par_q <= data_s;
            else if (data_s) begin
              data_low_q <= 1'b1;
              ack_q      <= 1'b1;
            end else begin
              ferr_q     <= 1'b1;
            end
          end
          if (at_end) begin
            if (ack_q) begin
              state <= ST_ACK_LO;
              ack_q <= 1'b0;
            end else begin
              if (bit_idx < STOP_SLOT) bit_idx <= bit_idx + 1'b1;
              state <= ST_RX_LO;
            end
          end
        end
        ST_ACK_LO: if (at_end) state <= ST_ACK_HI;
        ST_ACK_HI: begin
          if (at_end) begin
            data_low_q    <= 1'b0;
            rx_valid      <= 1'b1;
            rx_byte       <= sreg;
            rx_parity_err <= parity_bad(sreg, par_q);
            rx_frame_err  <= ferr_q;
            state         <= ST_RECOVER;
          end
        end
        ST_RECOVER: if (at_end) state <= ST_IDLE;
        default: state <= ST_RECOVER;
      endcase
    end
  end
endmodule

// File: rtl/ps2_dev_link_chk.sv
module ps2_dev_link_chk #(
  parameter int HALF_TICKS = 429
) (
  input logic clk,
  input logic rst_n,
  input logic clk_drive_low,
  input logic data_drive_low,
  input logic clk_line_in,
  input logic data_line_in,
  input logic tx_start,
  input logic tx_abort,
  input logic tx_ready,
  input logic rx_valid
);
  int low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             low_run <= 0;
    else if (clk_drive_low) low_run <= low_run + 1;
    else                    low_run <= 0;
  end

  // R3
  data_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_drive_low) |-> !clk_drive_low && !$past(clk_drive_low));

  // R4
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> $past(clk_line_in, 2) && $past(data_line_in, 2));

  // R6
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |=> !clk_drive_low && !data_drive_low && !tx_ready);

  // R8
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(data_drive_low) && !data_drive_low);

  // R11
  low_phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_drive_low) |-> low_run == HALF_TICKS);
endmodule

bind ps2_dev_link ps2_dev_link_chk #(.HALF_TICKS(HALF_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .clk_drive_low(clk_drive_low), .data_drive_low(data_drive_low),
  .clk_line_in(clk_line_in), .data_line_in(data_line_in),
  .tx_start(tx_start), .tx_abort(tx_abort),
  .tx_ready(tx_ready), .rx_valid(rx_valid)
);

// File: tb/ps2_dev_link_test.sv
module ps2_dev_link_test;
  localparam int HALF = 10;
  localparam int SAMP = 4;

  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic       tx_valid = 0;
  logic [7:0] tx_byte = 0;
  logic       host_clk_low = 0, host_data_low = 0;
  logic       tx_ready, tx_done, rx_valid, rx_parity_err, rx_frame_err;
  logic [7:0] rx_byte;
  logic       clk_drive_low, data_drive_low;

  wire clk_w  = !(clk_drive_low || host_clk_low);
  wire data_w = !(data_drive_low || host_data_low);

  ps2_dev_link #(.HALF_TICKS(HALF), .SAMPLE_TICKS(SAMP)) uut (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .tx_ready(tx_ready), .tx_done(tx_done), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err),
    .clk_line_in(clk_w), .data_line_in(data_w),
    .clk_drive_low(clk_drive_low), .data_drive_low(data_drive_low)
  );

  int checks = 0, fails = 0;
  int done_cnt = 0, fall_cnt = 0;
  logic dclk_q = 0, dd_q = 0;
  bit host_sending = 0;

  logic [7:0]  txq[$];
  logic [9:0]  rxq[$];
  string       rxtag[$];

  wire dev_fall = clk_drive_low && !dclk_q;

  always @(posedge clk) begin
    dclk_q <= clk_drive_low;
    dd_q   <= data_drive_low;
    if (tx_done) done_cnt <= done_cnt + 1;
    if (clk_drive_low && !dclk_q) fall_cnt <= fall_cnt + 1;
  end

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: host-side receive of device frames, scoreboard against txq
  int nbits = 0, idle = 0;
  logic [10:0] bits;
  bit r3_bad = 0;
  always @(negedge clk) begin
    if (!rst_n || host_sending) begin
      nbits = 0; idle = 0; r3_bad = 0;
    end else if (dev_fall) begin
      bits[nbits] = data_w;
      if (data_drive_low != dd_q) r3_bad = 1;
      nbits++; idle = 0;
      if (nbits == 11) begin
        if (txq.size() == 0) begin
          check_eq("R2", "unexpected frame", int'(bits), 0);
        end else begin
          logic [7:0] e;
          e = txq.pop_front();
          // R2 start 0, byte LSB first, odd parity, stop 1
          check_eq("R2", "frame bits", int'(bits), int'({1'b1, ~(^e), e, 1'b0}));
        end
        check_eq("R3", "data moved on a clock fall", int'(r3_bad), 0);
        nbits = 0; r3_bad = 0;
      end
    end else begin
      idle++;
      if (idle > 3 * HALF) begin nbits = 0; r3_bad = 0; end
    end
  end

  // scoreboard: received bytes
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (rxq.size() == 0) check_eq("R5", "unexpected rx_valid", 1, 0);
      else check_eq(rxtag.pop_front(), "rx {ferr,perr,byte}",
                    int'({rx_frame_err, rx_parity_err, rx_byte}), int'(rxq.pop_front()));
    end
  end

  task automatic wait_dev_fall();
    do @(negedge clk); while (!dev_fall);
  endtask

  task automatic dev_send(input logic [7:0] b);
    txq.push_back(b);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1; tx_byte = b;
    @(negedge clk);
    tx_valid = 0;
  endtask

  task automatic wait_done(input int target);
    while (done_cnt < target) @(negedge clk);
  endtask

  task automatic host_send(input logic [7:0] b, input bit bad_par, input bit bad_stop, input string tag);
    int last;
    last = bad_stop ? 13 : 11;
    host_sending = 1;
    rxq.push_back({bad_stop, bad_par, b});
    rxtag.push_back(tag);
    @(negedge clk);
    host_clk_low = 1;
    repeat (3 * HALF) @(negedge clk);
    host_data_low = 1;
    @(negedge clk);
    host_clk_low = 0;
    for (int n = 1; n <= last; n++) begin
      wait_dev_fall();
      if (n <= 8)       host_data_low = !b[n-1];
      else if (n == 9)  host_data_low = !(bad_par ? (^b) : ~(^b));
      else if (n == 10) host_data_low = bad_stop;
      else if (n == 12) host_data_low = 0;
      if (n == last) check_eq("R8", "data pulled at ack clock", int'(data_drive_low), 1);
    end
    while (!rx_valid) @(negedge clk);
    check_eq("R8", "data released with rx_valid", int'(data_drive_low), 0);
    repeat (2) @(negedge clk);
    host_sending = 0;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    int d0, f0, t;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check_eq("R1", "clk_drive_low", int'(clk_drive_low), 0);
    check_eq("R1", "data_drive_low", int'(data_drive_low), 0);
    check_eq("R1", "tx_ready", int'(tx_ready), 1);
    check_eq("R1", "rx_valid", int'(rx_valid), 0);

    // R2 and R11: several byte patterns
    dev_send(8'hA5);
    wait_dev_fall();
    t = 0;
    while (clk_drive_low) begin @(negedge clk); t++; end
    check_eq("R11", "low phase ticks", t, HALF);
    t = 0;
    while (!clk_drive_low) begin @(negedge clk); t++; end
    check_eq("R11", "high phase ticks", t, HALF);
    wait_done(1);
    dev_send(8'h00); wait_done(2);
    dev_send(8'hFF); wait_done(3);
    dev_send(8'h3C); wait_done(4);
    repeat (4 * HALF) @(negedge clk);
    check_eq("R2", "frames left unsent", txq.size(), 0);
    check_eq("R2", "tx_ready after frames", int'(tx_ready), 1);

    // R4 inhibit
    host_clk_low = 1;
    repeat (5) @(negedge clk);
    f0 = fall_cnt;
    dev_send(8'h5A);
    repeat (10 * HALF) @(negedge clk);
    check_eq("R4", "clocks during inhibit", fall_cnt - f0, 0);
    check_eq("R4", "data pulled during inhibit", int'(data_drive_low), 0);
    check_eq("R4", "tx_ready while pending", int'(tx_ready), 0);
    host_clk_low = 0;
    wait_done(5);
    repeat (4 * HALF) @(negedge clk);

    // R5 / R8 normal receive, R9 parity, R10 framing
    host_send(8'h96, 0, 0, "R5");
    host_send(8'h01, 0, 0, "R5");
    host_send(8'h42, 1, 0, "R9");
    host_send(8'h7E, 0, 1, "R10");
    check_eq("R5", "rx items left", rxq.size(), 0);

    // R6 early contention
    d0 = done_cnt;
    dev_send(8'hC3);
    repeat (3) wait_dev_fall();
    host_clk_low = 1;
    repeat (4 * HALF) @(negedge clk);
    check_eq("R6", "clk_drive_low after abort", int'(clk_drive_low), 0);
    check_eq("R6", "data_drive_low after abort", int'(data_drive_low), 0);
    check_eq("R6", "tx_ready keeps byte", int'(tx_ready), 0);
    check_eq("R6", "tx_done on abort", done_cnt - d0, 0);
    f0 = fall_cnt;
    repeat (2 * HALF) @(negedge clk);
    check_eq("R6", "clocks while held", fall_cnt - f0, 0);
    host_clk_low = 0;
    wait_done(d0 + 1);
    repeat (4 * HALF) @(negedge clk);
    check_eq("R6", "retried frame delivered", txq.size(), 0);

    // R7 late contention
    d0 = done_cnt;
    dev_send(8'h81);
    repeat (10) wait_dev_fall();
    while (clk_drive_low) @(negedge clk);
    host_clk_low = 1;
    wait_done(d0 + 1);
    f0 = fall_cnt;
    repeat (10 * HALF) @(negedge clk);
    check_eq("R7", "no retry clocks", fall_cnt - f0, 0);
    check_eq("R7", "tx_ready after late pull", int'(tx_ready), 1);
    check_eq("R7", "frame completed", txq.size(), 0);
    host_clk_low = 0;
    repeat (30 * HALF) @(negedge clk);
    check_eq("R7", "single tx_done", done_cnt - d0, 1);

    finish_up();
  end
endmodule